// File: doc/BRIEF.md
# Interval Timer Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host writes control words and count bytes through an 8-bit port, and reads counts back through the same port. Each channel has its own count path. The port gives every channel a counting mode, a decimal-count flag and a 16-bit reload value with a one-cycle load pulse. It takes each channel's live count back in. The count engines sit outside this block, and the decimal flag is only stored here.

For each channel the port remembers how data bytes are laid out: low byte only, high byte only, or low byte followed by high byte. In the two-byte layout one shared byte pointer steps through the pair on both writes and reads. A latch command freezes a copy of a channel's live count. Later reads then return that copy one byte at a time, so a 16-bit value can be read back consistently while the count keeps running.

There is no data stream with a handshake here. Write and read strobes are plain single-cycle controls that are accepted on every clock, with no back-pressure. Read data is returned from a register one clock after the read strobe.

Top module: `itimer_host_if`

## Requirements
- R1: After reset every channel reports mode 3 and flag 0, uses the low-then-high layout with the pointer on the low byte, and holds no latched copy. All load pulses are 0, every reload value is 0 and rd_data is 0.
- R2: A write to address 3 is a control word. Bits 7:6 select channel 0, 1 or 2. The select value 3 causes no change to any channel.
- R3: A control word with bits 5:4 not 00 sets the selected channel's mode from bits 3:1 and its flag from bit 0. It sets the byte layout from bits 5:4 (01 low only, 10 high only, 11 low then high). It returns the pointer to the low byte and discards any latched copy.
- R4: In the low-only layout, a data write to address n (0 to 2) sets channel n's reload value to {8'h00, byte}. load_pulse[n] is high for exactly the one cycle after the write clock.
- R5: In the high-only layout, a data write sets the reload value to {byte, 8'h00} and pulses the load in the same way.
- R6: In the low-then-high layout, the first data write only stores the byte. The second write loads {new byte, stored byte} and pulses the load. The pointer flips after each write.
- R7: A control word with bits 5:4 equal to 00 copies the selected channel's live count at that clock edge. The next two reads of that channel return the copy's low byte, then its high byte, whatever the live count does in the meantime.
- R8: The copy is kept until both of its bytes have been read. A latch command for a channel that already holds a copy is ignored.
- R9: With no copy held, a read returns the live count's low byte (low-only layout) or high byte (high-only layout) and leaves the pointer alone. In the low-then-high layout the read follows the shared pointer and then flips it.
- R10: A read of address 3 returns 0 and changes no state. A read strobe raised together with a write strobe is ignored.
- R11: rd_data takes the read result on the clock edge that samples rd_en and holds it until the next accepted read.
- R12: Data writes follow the byte layout even while a copy is held, and they leave the copy and its byte order untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | 0 to 2 select a channel data port; 3 is the control port |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; ignored while wr_en is high |
| rd_data | output | 8 | Registered read byte |
| live_count | input | NUM_CH*CNT_W | Live count of each channel, channel 0 in the low bits |
| ch_mode | output | NUM_CH*3 | Counting mode of each channel |
| ch_bcd | output | NUM_CH | Decimal-count flag of each channel |
| load_pulse | output | NUM_CH | One-cycle reload strobe per channel |
| load_value | output | NUM_CH*CNT_W | Reload value of each channel |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit count and 8-bit bytes. With these values the 2-bit select field covers every channel plus the reserved select value 3, and each count splits into exactly two bytes, so every layout and every pointer position can be reached. Each channel's live count runs at a different rate, so a latched copy visibly differs from the live value by the time it is read. A long pseudo-random phase mixes latch commands, reprogramming, reserved selects and collided strobes on all three channels.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [2:0] RST_MODE  = 3'd3;
endpackage

// File: rtl/itimer_cw_decode.sv
module itimer_cw_decode
  import itimer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NUM_CH-1:0] prog_hit,
  output logic [NUM_CH-1:0] latch_hit,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] data_rd,
  output logic              rd_acc,
  output acc_e              cw_acc,
  output logic [2:0]        cw_mode,
  output logic              cw_bcd
);
  logic [1:0] cw_sel;
  logic       is_cw;

  always_comb begin
    cw_sel  = wr_data[7:6];
    cw_acc  = acc_e'(wr_data[5:4]);
    cw_mode = wr_data[3:1];
    cw_bcd  = wr_data[0];
    is_cw   = wr_en && (addr == CTRL_ADDR);
    rd_acc  = rd_en && !wr_en;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_comb begin
      prog_hit[i]  = is_cw && (cw_sel == 2'(i)) && (cw_acc != ACC_LATCH);
      latch_hit[i] = is_cw && (cw_sel == 2'(i)) && (cw_acc == ACC_LATCH);
      data_wr[i]   = wr_en && (addr == 2'(i));
      data_rd[i]   = rd_acc && (addr == 2'(i));
    end
  end
endmodule

// File: rtl/itimer_chan_seq.sv
module itimer_chan_seq
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              latch,
  input  acc_e              cw_acc,
  input  logic [2:0]        cw_mode,
  input  logic              cw_bcd,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              pulse,
  output logic [CNT_W-1:0]  value,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int HI_SHIFT = BYTE_W;

  acc_e              acc_q;
  logic              ptr_q;
  logic              lat_q;
  logic              lptr_q;
  logic [CNT_W-1:0]  snap_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= RST_MODE;
      bcd    <= 1'b0;
      acc_q  <= ACC_WORD;
      ptr_q  <= 1'b0;
      lat_q  <= 1'b0;
      lptr_q <= 1'b0;
      snap_q <= '0;
      hold_q <= '0;
      pulse  <= 1'b0;
      value  <= '0;
    end else begin
      pulse <= 1'b0;
      if (prog) begin
        mode   <= cw_mode;
        bcd    <= cw_bcd;
        acc_q  <= cw_acc;
        ptr_q  <= 1'b0;
        lat_q  <= 1'b0;
        lptr_q <= 1'b0;
      end else if (latch && !lat_q) begin
        lat_q  <= 1'b1;
        lptr_q <= 1'b0;
        snap_q <= live;
      end
      if (wr) begin
        case (acc_q)
          ACC_HI: begin
            value <= CNT_W'(wdata) << HI_SHIFT;
            pulse <= 1'b1;
          end
          ACC_WORD: begin
            if (!ptr_q) begin
              hold_q <= wdata;
              ptr_q  <= 1'b1;
            end else begin
              value <= (CNT_W'(wdata) << HI_SHIFT) | CNT_W'(hold_q);
              pulse <= 1'b1;
              ptr_q <= 1'b0;
            end
          end
          default: begin
            value <= CNT_W'(wdata);
            pulse <= 1'b1;
          end
        endcase
      end
      if (rd) begin
        if (lat_q) begin
          lptr_q <= ~lptr_q;
          if (lptr_q) lat_q <= 1'b0;
        end else if (acc_q == ACC_WORD) begin
          ptr_q <= ~ptr_q;
        end
      end
    end
  end

  always_comb begin
    if (lat_q) begin
      rbyte = lptr_q ? BYTE_W'(snap_q >> HI_SHIFT) : snap_q[BYTE_W-1:0];
    end else begin
      case (acc_q)
        ACC_HI:   rbyte = BYTE_W'(live >> HI_SHIFT);
        ACC_WORD: rbyte = ptr_q ? BYTE_W'(live >> HI_SHIFT) : live[BYTE_W-1:0];
        default:  rbyte = live[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/itimer_rd_mux.sv
module itimer_rd_mux #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic [NUM_CH-1:0]        sel,
  input  logic [NUM_CH*BYTE_W-1:0] bytes_in,
  output logic [BYTE_W-1:0]        byte_out
);
  always_comb begin
    byte_out = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      byte_out = byte_out | (bytes_in[i*BYTE_W +: BYTE_W] & {BYTE_W{sel[i]}});
    end
  end
endmodule

// File: rtl/itimer_host_if.sv
module itimer_host_if
  import itimer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               addr,
  input  logic                     wr_en,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     rd_en,
  output logic [BYTE_W-1:0]        rd_data,
  input  logic [NUM_CH*CNT_W-1:0]  live_count,
  output logic [NUM_CH*3-1:0]      ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd,
  output logic [NUM_CH-1:0]        load_pulse,
  output logic [NUM_CH*CNT_W-1:0]  load_value
);
  logic [NUM_CH-1:0]        prog_hit;
  logic [NUM_CH-1:0]        latch_hit;
  logic [NUM_CH-1:0]        data_wr;
  logic [NUM_CH-1:0]        data_rd;
  logic                     rd_acc;
  acc_e                     cw_acc;
  logic [2:0]               cw_mode;
  logic                     cw_bcd;
  logic [NUM_CH*BYTE_W-1:0] rbytes;
  logic [BYTE_W-1:0]        rsel;

  itimer_cw_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .prog_hit  (prog_hit),
    .latch_hit (latch_hit),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .rd_acc    (rd_acc),
    .cw_acc    (cw_acc),
    .cw_mode   (cw_mode),
    .cw_bcd    (cw_bcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    itimer_chan_seq #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .prog    (prog_hit[i]),
      .latch   (latch_hit[i]),
      .cw_acc  (cw_acc),
      .cw_mode (cw_mode),
      .cw_bcd  (cw_bcd),
      .wr      (data_wr[i]),
      .rd      (data_rd[i]),
      .wdata   (wr_data),
      .live    (live_count[i*CNT_W +: CNT_W]),
      .mode    (ch_mode[i*3 +: 3]),
      .bcd     (ch_bcd[i]),
      .pulse   (load_pulse[i]),
      .value   (load_value[i*CNT_W +: CNT_W]),
      .rbyte   (rbytes[i*BYTE_W +: BYTE_W])
    );
  end

  itimer_rd_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_mux (
    .sel      (data_rd),
    .bytes_in (rbytes),
    .byte_out (rsel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_acc) rd_data <= rsel;
  end
endmodule

// File: rtl/itimer_host_if_chk.sv
module itimer_host_if_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              addr,
  input logic                    wr_en,
  input logic [BYTE_W-1:0]       wr_data,
  input logic                    rd_en,
  input logic [BYTE_W-1:0]       rd_data,
  input logic [NUM_CH*CNT_W-1:0] live_count,
  input logic [NUM_CH*3-1:0]     ch_mode,
  input logic [NUM_CH-1:0]       ch_bcd,
  input logic [NUM_CH-1:0]       load_pulse,
  input logic [NUM_CH*CNT_W-1:0] load_value
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) load_pulse[i] |-> $past(wr_en && (addr == 2'(i)))); // R4
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load_pulse[i] |-> $stable(load_value[i*CNT_W +: CNT_W])); // R6
  end
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en && (addr == 2'd3)) |-> $stable(ch_mode) && $stable(ch_bcd)); // R3
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_en && (addr == 2'd3) && (wr_data[7:6] == 2'd3)) |-> $stable(ch_mode) && $stable(ch_bcd)); // R2
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $past(rd_en && !wr_en && (addr == 2'd3)) |-> (rd_data == '0)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(rd_en && !wr_en) |-> $stable(rd_data)); // R11
endmodule

bind itimer_host_if itimer_host_if_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/itimer_host_if_tb.sv
module itimer_host_if_tb;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n;
  logic [1:0]              addr;
  logic                    wr_en;
  logic [BYTE_W-1:0]       wr_data;
  logic                    rd_en;
  logic [BYTE_W-1:0]       rd_data;
  logic [NUM_CH*CNT_W-1:0] live_count;
  logic [NUM_CH*3-1:0]     ch_mode;
  logic [NUM_CH-1:0]       ch_bcd;
  logic [NUM_CH-1:0]       load_pulse;
  logic [NUM_CH*CNT_W-1:0] load_value;
  logic [CNT_W-1:0]        live_v [NUM_CH];

  always_comb
    for (int c = 0; c < NUM_CH; c++) live_count[c*CNT_W +: CNT_W] = live_v[c];

  itimer_host_if #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .live_count(live_count), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .load_pulse(load_pulse), .load_value(load_value)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_mode[NUM_CH], m_bcd[NUM_CH], m_acc[NUM_CH], m_ptr[NUM_CH];
  int m_lat[NUM_CH], m_lptr[NUM_CH], m_snap[NUM_CH], m_hold[NUM_CH];
  int m_val[NUM_CH], m_pulse[NUM_CH];
  int m_rd;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      m_mode[c] = 3; m_bcd[c] = 0; m_acc[c] = 3; m_ptr[c] = 0;
      m_lat[c] = 0; m_lptr[c] = 0; m_snap[c] = 0; m_hold[c] = 0;
      m_val[c] = 0; m_pulse[c] = 0;
    end
    m_rd = 0;
  endtask

  task automatic model_apply(int a, int w, int r, int d);
    for (int c = 0; c < NUM_CH; c++) m_pulse[c] = 0;
    if (w != 0) begin
      if (a == 3) begin
        int ch = (d >> 6) & 3;
        int ac = (d >> 4) & 3;
        if (ch < NUM_CH) begin
          if (ac == 0) begin
            if (m_lat[ch] == 0) begin
              m_lat[ch] = 1; m_lptr[ch] = 0; m_snap[ch] = int'(live_v[ch]);
            end
          end else begin
            m_mode[ch] = (d >> 1) & 7; m_bcd[ch] = d & 1; m_acc[ch] = ac;
            m_ptr[ch] = 0; m_lat[ch] = 0; m_lptr[ch] = 0;
          end
        end
      end else if (m_acc[a] == 1) begin
        m_val[a] = d; m_pulse[a] = 1;
      end else if (m_acc[a] == 2) begin
        m_val[a] = d * 256; m_pulse[a] = 1;
      end else if (m_ptr[a] == 0) begin
        m_hold[a] = d; m_ptr[a] = 1;
      end else begin
        m_val[a] = d * 256 + m_hold[a]; m_pulse[a] = 1; m_ptr[a] = 0;
      end
    end else if (r != 0) begin
      if (a == 3) m_rd = 0;
      else if (m_lat[a] != 0) begin
        m_rd = (m_lptr[a] != 0) ? (m_snap[a] >> 8) & 255 : m_snap[a] & 255;
        if (m_lptr[a] != 0) m_lat[a] = 0;
        m_lptr[a] = 1 - m_lptr[a];
      end else begin
        int lv = int'(live_v[a]);
        if (m_acc[a] == 1) m_rd = lv & 255;
        else if (m_acc[a] == 2) m_rd = (lv >> 8) & 255;
        else begin
          m_rd = (m_ptr[a] != 0) ? (lv >> 8) & 255 : lv & 255;
          m_ptr[a] = 1 - m_ptr[a];
        end
      end
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NUM_CH; c++) begin
      chk($sformatf("pulse ch%0d", c), int'(load_pulse[c]), m_pulse[c]);
      chk($sformatf("value ch%0d", c), int'(load_value[c*CNT_W +: CNT_W]), m_val[c]);
      chk($sformatf("mode ch%0d", c), int'(ch_mode[c*3 +: 3]), m_mode[c]);
      chk($sformatf("bcd ch%0d", c), int'(ch_bcd[c]), m_bcd[c]);
    end
    chk("rd_data", int'(rd_data), m_rd);
  endtask

  task automatic step(int a, int w, int r, int d);
    @(negedge clk);
    addr = 2'(a); wr_en = w[0]; rd_en = r[0]; wr_data = 8'(d);
    for (int c = 0; c < NUM_CH; c++) live_v[c] = live_v[c] - CNT_W'(c + 1);
    @(posedge clk);
    #1;
    model_apply(a, w, r, d);
    compare_all();
  endtask

  task automatic wr(int a, int d); step(a, 1, 0, d); endtask
  task automatic rd(int a);        step(a, 0, 1, 0); endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    live_v[0] = 16'h1357; live_v[1] = 16'hA4C2; live_v[2] = 16'h7F01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    cur_req = "R1";   // reset state
    compare_all();
    idle(2);

    cur_req = "R9";   // default low-then-high live read on ch0
    rd(0); rd(0);

    cur_req = "R4";   // ch0 low only, mode 2: 00_01_010_0
    wr(3, 8'h14); wr(0, 8'h5A); idle(1);

    cur_req = "R5";   // ch1 high only, mode 3, flag: 01_10_011_1
    wr(3, 8'h67); wr(1, 8'hC3); idle(1);

    cur_req = "R6";   // ch2 low then high: 10_11_000_0
    wr(3, 8'hB0); wr(2, 8'h34); idle(2); wr(2, 8'h12); idle(1);

    cur_req = "R2";   // reserved select leaves all channels alone
    wr(3, 8'hFF); wr(3, 8'hC0); wr(3, 8'hD6); idle(1);
    wr(0, 8'h77);

    cur_req = "R7";   // latch ch2, let live run, read copy
    wr(3, 8'h80); idle(5); rd(2); idle(3); rd(2);
    rd(2); rd(2);

    cur_req = "R8";   // second latch while copy held is ignored
    wr(3, 8'h40); idle(2); rd(1); wr(3, 8'h40); idle(4); rd(1); rd(1);

    cur_req = "R9";   // live reads in single-byte layouts do not step
    rd(0); rd(0); rd(1); rd(1);

    cur_req = "R12";  // data write during held copy
    wr(3, 8'h00); idle(2); wr(0, 8'h9E); rd(0); wr(0, 8'h21); rd(0); rd(0);

    cur_req = "R3";   // reprogram discards copy, resets pointer
    wr(3, 8'hB7); rd(2); wr(3, 8'h80); rd(2); wr(3, 8'hB5); rd(2); rd(2);

    cur_req = "R10";  // control-port read, collided strobes
    rd(1); rd(3); step(0, 1, 1, 8'h44); rd(3); step(3, 1, 1, 8'h15);

    cur_req = "R11";  // read value holds while idle
    rd(2); idle(4);

    cur_req = "R6";   // mixed pseudo-random traffic
    seed = 32'h1ACE;
    for (int n = 0; n < 600; n++) begin
      int a, w, r, d;
      seed = seed * 1103515245 + 12345;
      a = (seed >> 16) & 3;
      w = ((seed >> 19) & 3) == 0 ? 1 : 0;
      r = ((seed >> 21) & 1);
      d = (seed >> 8) & 255;
      if (a == 3 && w != 0 && ((d >> 4) & 3) != 0 && ((seed >> 24) & 1) != 0) d = d | 8'h30;
      step(a, w, r, d);
    end
    idle(2);
    finish_run();
  end
endmodule